// File: doc/BRIEF.md
# Privileged Control-Register Access Unit

This block carries out the three privileged control-register instructions of a small processor core: read, write and masked exchange. A request names a 14-bit control-register number and carries a write-data operand, a mask operand and the privilege level the instruction runs at. One cycle after the request is accepted, the block returns the value for the destination register. It also returns three flags: a privilege exception, an illegal-instruction trap and a request to flush the pipeline.

The registers themselves live inside the block. There are six named writable registers, sixteen scratch registers, four address-window registers and four read-only identification registers. The read-only registers hold a core identifier and three configuration words, and their values come from parameters. Control-register numbers that name nothing read as zero and swallow writes. A write that changes the operating mode or the extension-enable register asks the pipeline to flush, so that later instructions see the new state.

Top module: `csr_access_unit`

## Requirements
- R1: After reset `resp_valid` is 0 and `req_ready` is 1. Every writable register reads 0. The core identifier (number 0x020) reads the `CORE_ID` parameter, and the configuration words at 0x021, 0x022 and 0x023 read `CFG0`, `CFG1` and `CFG2`.
- R2: A request at privilege level 3 (user) returns `resp_priv_exc`=1 and data 0, with no flush and no change to any register. The other levels are 0, 1 and 2.
- R3: A read (`req_op`=0) of a number that names no register returns 0 and raises no flag.
- R4: A write (`req_op`=1) or exchange (`req_op`=2) to a number that names no register returns 0, raises no flag and changes no register.
- R5: A write or exchange to a read-only register raises `resp_illegal`, returns 0 and leaves the register's value as it was.
- R6: A write returns the register's previous contents and stores the write operand.
- R7: An exchange stores (data AND mask) OR (old AND NOT mask) and returns the old value.
- R8: `resp_flush` is 1 exactly when a write or exchange that is neither trapped nor excepted targets the mode register (0x000) or the extension-enable register (0x002). Reads never flush.
- R9: Scratch register i sits at number 0x030+i (i = 0..15) and address-window register j at 0x180+j (j = 0..3). Each holds its own value. The other writable registers are at 0x000, 0x001, 0x002, 0x004, 0x006 and 0x007.
- R10: Operation code 3 is reserved. It raises `resp_illegal`, returns 0 and changes no register.
- R11: A request is accepted when `req_valid` and `req_ready` are both 1. The response appears in the next cycle and is held stable while `resp_ready` is 0. During that time `req_ready` stays 0. A write lands at the edge that accepts it, so a read accepted in the next cycle sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_op | input | 2 | 0 read, 1 write, 2 exchange, 3 reserved |
| req_csr | input | 14 | Control-register number |
| req_wdata | input | W | Write-data operand |
| req_mask | input | W | Mask operand for exchange |
| req_priv | input | 2 | Privilege level, 3 is user |
| resp_ready | input | 1 | Response consumer ready |
| resp_valid | output | 1 | Response present |
| resp_data | output | W | Value for the destination register |
| resp_priv_exc | output | 1 | Privilege exception |
| resp_illegal | output | 1 | Illegal-instruction trap |
| resp_flush | output | 1 | Pipeline flush request |

## Verification
Two functions can fall in the same cycle. One is the register update of an accepted write or exchange. The other is the read-out for the request accepted right after it, or the holding of a pending response against a new request. The bench issues requests back to back, one per cycle, across the whole 14-bit number space. Every returned value is judged against a model in the bench that has already applied the previous request. The bench also holds `resp_ready` low while a second request waits. It checks that the response stays still and that the waiting read is accepted only after release, when it returns the freshly written value.

// File: rtl/csr_unit_pkg.sv
package csr_unit_pkg;

    localparam int CSR_NUM_W = 14;
    localparam int SLOT_W    = 8;
    localparam int NUM_NAMED = 6;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_XCHG  = 2'd2,
        OP_RSVD  = 2'd3
    } csr_op_e;

    localparam logic [1:0] PRIV_USER = 2'd3;

    localparam logic [CSR_NUM_W-1:0] A_MODE     = 14'h000;
    localparam logic [CSR_NUM_W-1:0] A_PMODE    = 14'h001;
    localparam logic [CSR_NUM_W-1:0] A_EXTEN    = 14'h002;
    localparam logic [CSR_NUM_W-1:0] A_EXCFG    = 14'h004;
    localparam logic [CSR_NUM_W-1:0] A_EPC      = 14'h006;
    localparam logic [CSR_NUM_W-1:0] A_BADADDR  = 14'h007;
    localparam logic [CSR_NUM_W-1:0] A_CORE_ID  = 14'h020;
    localparam logic [CSR_NUM_W-1:0] A_CFG_BASE = 14'h021;
    localparam logic [CSR_NUM_W-1:0] A_SCR_BASE = 14'h030;
    localparam logic [CSR_NUM_W-1:0] A_WIN_BASE = 14'h180;

    typedef struct packed {
        logic              known;
        logic              ro;
        logic              flush;
        logic [1:0]        ro_sel;
        logic [SLOT_W-1:0] slot;
    } csr_attr_t;

    function automatic logic writes_reg(csr_op_e op);
        return (op == OP_WRITE) || (op == OP_XCHG);
    endfunction

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_unit_pkg::*;
#(
    parameter int NUM_SCRATCH = 16,
    parameter int NUM_WINDOW  = 4
) (
    input  logic [CSR_NUM_W-1:0] csr_num,
    output csr_attr_t            attr
);
    localparam int SCR_SLOT0 = NUM_NAMED;
    localparam int WIN_SLOT0 = NUM_NAMED + NUM_SCRATCH;

    int scr_off;
    int win_off;

    always_comb begin
        attr    = '0;
        scr_off = int'(csr_num) - int'(A_SCR_BASE);
        win_off = int'(csr_num) - int'(A_WIN_BASE);
        case (csr_num)
            A_MODE:    begin attr.known = 1'b1; attr.flush = 1'b1; attr.slot = SLOT_W'(0); end
            A_PMODE:   begin attr.known = 1'b1; attr.slot = SLOT_W'(1); end
            A_EXTEN:   begin attr.known = 1'b1; attr.flush = 1'b1; attr.slot = SLOT_W'(2); end
            A_EXCFG:   begin attr.known = 1'b1; attr.slot = SLOT_W'(3); end
            A_EPC:     begin attr.known = 1'b1; attr.slot = SLOT_W'(4); end
            A_BADADDR: begin attr.known = 1'b1; attr.slot = SLOT_W'(5); end
            A_CORE_ID: begin attr.known = 1'b1; attr.ro = 1'b1; attr.ro_sel = 2'd0; end
            A_CFG_BASE: begin attr.known = 1'b1; attr.ro = 1'b1; attr.ro_sel = 2'd1; end
            A_CFG_BASE + 14'd1: begin attr.known = 1'b1; attr.ro = 1'b1; attr.ro_sel = 2'd2; end
            A_CFG_BASE + 14'd2: begin attr.known = 1'b1; attr.ro = 1'b1; attr.ro_sel = 2'd3; end
            default: begin
                if (scr_off >= 0 && scr_off < NUM_SCRATCH) begin
                    attr.known = 1'b1;
                    attr.slot  = SLOT_W'(SCR_SLOT0 + scr_off);
                end else if (win_off >= 0 && win_off < NUM_WINDOW) begin
                    attr.known = 1'b1;
                    attr.slot  = SLOT_W'(WIN_SLOT0 + win_off);
                end
            end
        endcase
    end
endmodule

// File: rtl/csr_store.sv
module csr_store
    import csr_unit_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SLOT_W-1:0] slot,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rdata
);
    logic [W-1:0] bank [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && int'(slot) == i) begin
                q <= wdata;
            end
        end
        assign bank[i] = q;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(slot) == k) rdata = bank[k];
        end
    end
endmodule

// File: rtl/csr_merge.sv
module csr_merge
    import csr_unit_pkg::*;
#(
    parameter int W = 32
) (
    input  csr_op_e      op,
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] data,
    input  logic [W-1:0] mask,
    output logic [W-1:0] new_val
);
    always_comb begin
        case (op)
            OP_WRITE: new_val = data;
            OP_XCHG:  new_val = (data & mask) | (old_val & ~mask);
            default:  new_val = old_val;
        endcase
    end
endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_unit_pkg::*;
#(
    parameter int          W           = 32,
    parameter int          NUM_SCRATCH = 16,
    parameter int          NUM_WINDOW  = 4,
    parameter logic [31:0] CORE_ID     = 32'h0000_0007,
    parameter logic [31:0] CFG0        = 32'h1234_0001,
    parameter logic [31:0] CFG1        = 32'h1234_0002,
    parameter logic [31:0] CFG2        = 32'h1234_0003
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [CSR_NUM_W-1:0] req_csr,
    input  logic [W-1:0]         req_wdata,
    input  logic [W-1:0]         req_mask,
    input  logic [1:0]           req_priv,
    input  logic                 resp_ready,
    output logic                 resp_valid,
    output logic [W-1:0]         resp_data,
    output logic                 resp_priv_exc,
    output logic                 resp_illegal,
    output logic                 resp_flush
);
    localparam int DEPTH = NUM_NAMED + NUM_SCRATCH + NUM_WINDOW;

    csr_op_e      op;
    csr_attr_t    attr;
    logic         accept;
    logic         is_user;
    logic         trap_ill;
    logic         do_write;
    logic [W-1:0] store_rd;
    logic [W-1:0] ro_val;
    logic [W-1:0] old_val;
    logic [W-1:0] new_val;
    logic [W-1:0] nxt_data;
    logic         nxt_flush;

    assign op        = csr_op_e'(req_op);
    assign req_ready = !resp_valid || resp_ready;
    assign accept    = req_valid && req_ready;

    csr_decode #(.NUM_SCRATCH(NUM_SCRATCH), .NUM_WINDOW(NUM_WINDOW)) u_dec (
        .csr_num (req_csr),
        .attr    (attr)
    );

    csr_store #(.W(W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (do_write),
        .slot  (attr.slot),
        .wdata (new_val),
        .rdata (store_rd)
    );

    csr_merge #(.W(W)) u_merge (
        .op      (op),
        .old_val (old_val),
        .data    (req_wdata),
        .mask    (req_mask),
        .new_val (new_val)
    );

    always_comb begin
        case (attr.ro_sel)
            2'd0:    ro_val = W'(CORE_ID);
            2'd1:    ro_val = W'(CFG0);
            2'd2:    ro_val = W'(CFG1);
            default: ro_val = W'(CFG2);
        endcase
    end

    assign old_val = attr.ro ? ro_val : store_rd;
    assign is_user = (req_priv == PRIV_USER);

    always_comb begin
        trap_ill  = !is_user && ((op == OP_RSVD) || (attr.known && attr.ro && writes_reg(op)));
        do_write  = accept && !is_user && attr.known && !attr.ro && writes_reg(op);
        nxt_flush = !is_user && attr.known && !attr.ro && attr.flush && writes_reg(op);
        if (!is_user && !trap_ill && attr.known) nxt_data = old_val;
        else                                     nxt_data = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid    <= 1'b0;
            resp_data     <= '0;
            resp_priv_exc <= 1'b0;
            resp_illegal  <= 1'b0;
            resp_flush    <= 1'b0;
        end else if (accept) begin
            resp_valid    <= 1'b1;
            resp_data     <= nxt_data;
            resp_priv_exc <= is_user;
            resp_illegal  <= trap_ill;
            resp_flush    <= nxt_flush;
        end else if (resp_ready) begin
            resp_valid    <= 1'b0;
        end
    end
endmodule

// File: rtl/csr_access_unit_chk.sv
module csr_access_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_ready,
    input logic [1:0]   req_op,
    input logic [1:0]   req_priv,
    input logic         resp_ready,
    input logic         resp_valid,
    input logic [W-1:0] resp_data,
    input logic         resp_priv_exc,
    input logic         resp_illegal,
    input logic         resp_flush
);
    // R11
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    // R11
    stall_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |-> !req_ready);

    // R11
    held_resp_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

    // R2
    user_excepts_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_priv == 2'd3) |=> (resp_priv_exc && resp_data == '0));

    // R8
    read_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 2'd0) |=> !resp_flush);

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $onehot0({resp_priv_exc, resp_illegal, resp_flush}));

    // R10
    reserved_traps_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_op == 2'd3 && req_priv != 2'd3) |=> (resp_illegal && resp_data == '0));
endmodule

bind csr_access_unit csr_access_unit_chk #(.W(W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_priv      (req_priv),
    .resp_ready    (resp_ready),
    .resp_valid    (resp_valid),
    .resp_data     (resp_data),
    .resp_priv_exc (resp_priv_exc),
    .resp_illegal  (resp_illegal),
    .resp_flush    (resp_flush)
);

// File: tb/csr_access_unit_test.sv
`timescale 1ns/1ps
module csr_access_unit_test;
    localparam int          W   = 32;
    localparam logic [31:0] CID = 32'h0000_0007;
    localparam logic [31:0] C0  = 32'h1234_0001;
    localparam logic [31:0] C1  = 32'h1234_0002;
    localparam logic [31:0] C2  = 32'h1234_0003;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'd0;
    logic [13:0]  req_csr = '0;
    logic [W-1:0] req_wdata = '0;
    logic [W-1:0] req_mask = '0;
    logic [1:0]   req_priv = 2'd0;
    logic         resp_ready = 1'b1;
    logic         resp_valid;
    logic [W-1:0] resp_data;
    logic         resp_priv_exc;
    logic         resp_illegal;
    logic         resp_flush;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] mdl [0:25];

    always #2 clk = ~clk;

    csr_access_unit #(.W(W), .CORE_ID(CID), .CFG0(C0), .CFG1(C1), .CFG2(C2)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_csr(req_csr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_priv(req_priv), .resp_ready(resp_ready), .resp_valid(resp_valid),
        .resp_data(resp_data), .resp_priv_exc(resp_priv_exc), .resp_illegal(resp_illegal),
        .resp_flush(resp_flush)
    );

    // Map from the requirement text: -1 none, 0..25 writable slot, 100..103 read-only
    function automatic int slot_of(logic [13:0] c);
        case (c)
            14'h000: return 0;
            14'h001: return 1;
            14'h002: return 2;
            14'h004: return 3;
            14'h006: return 4;
            14'h007: return 5;
            14'h020: return 100;
            14'h021: return 101;
            14'h022: return 102;
            14'h023: return 103;
            default: begin
                if (c >= 14'h030 && c <= 14'h03F) return 6 + int'(c - 14'h030);
                if (c >= 14'h180 && c <= 14'h183) return 22 + int'(c - 14'h180);
                return -1;
            end
        endcase
    endfunction

    function automatic logic [W-1:0] ro_value(int s);
        case (s)
            100: return CID;
            101: return C0;
            102: return C1;
            default: return C2;
        endcase
    endfunction

    task automatic check(string tag, logic [W-1:0] d, logic pe, logic il, logic fl);
        checks++;
        if (!resp_valid || resp_data !== d || resp_priv_exc !== pe ||
            resp_illegal !== il || resp_flush !== fl) begin
            errors++;
            $display("FAIL %s csr=%h: got v=%b d=%h pe=%b il=%b fl=%b, want v=1 d=%h pe=%b il=%b fl=%b",
                     tag, req_csr, resp_valid, resp_data, resp_priv_exc, resp_illegal, resp_flush,
                     d, pe, il, fl);
        end
    endtask

    // Compute the expected response and update the model, then drive for one cycle
    task automatic issue(logic [1:0] op, logic [13:0] c, logic [W-1:0] wd,
                         logic [W-1:0] m, logic [1:0] pv);
        int s;
        logic [W-1:0] ed;
        logic epe, eil, efl;
        string tag;
        s = slot_of(c);
        ed = '0; epe = 1'b0; eil = 1'b0; efl = 1'b0;
        if (pv == 2'd3) begin
            epe = 1'b1; tag = "R2";
        end else if (op == 2'd3) begin
            eil = 1'b1; tag = "R10";
        end else if (s < 0) begin
            tag = (op == 2'd0) ? "R3" : "R4";
        end else if (s >= 100) begin
            if (op == 2'd0) begin ed = ro_value(s); tag = "R1"; end
            else begin eil = 1'b1; tag = "R5"; end
        end else begin
            ed = mdl[s];
            if (op == 2'd0) tag = "R9";
            else begin
                efl = (c == 14'h000 || c == 14'h002);
                if (op == 2'd1) begin mdl[s] = wd; tag = efl ? "R8" : "R6"; end
                else begin mdl[s] = (wd & m) | (ed & ~m); tag = efl ? "R8" : "R7"; end
            end
        end
        req_valid = 1'b1; req_op = op; req_csr = c; req_wdata = wd; req_mask = m; req_priv = pv;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(tag, ed, epe, eil, efl);
    endtask

    task automatic read_sweep();
        for (int c = 0; c < 16384; c++) issue(2'd0, 14'(c), '0, '0, 2'd0);
    endtask

    initial begin
        for (int i = 0; i < 26; i++) mdl[i] = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state at the ports
        checks++;
        if (resp_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1 reset: valid=%b ready=%b, want 0 1", resp_valid, req_ready);
        end
        issue(2'd0, 14'h020, '0, '0, 2'd0);   // R1 core id
        issue(2'd0, 14'h023, '0, '0, 2'd1);   // R1 last config word

        // R1 R3 all numbers after reset
        read_sweep();

        // R2 user level: mixed ops, nothing may change
        for (int c = 0; c < 1024; c++)
            issue(2'(c % 3), 14'(c), {2'b11, 14'(c), 2'b00, 14'(c)}, 32'hFFFF_FFFF, 2'd3);

        // R10 reserved op on defined, read-only and undefined numbers
        issue(2'd3, 14'h000, 32'hDEAD_BEEF, '1, 2'd0);
        issue(2'd3, 14'h021, 32'hDEAD_BEEF, '1, 2'd1);
        issue(2'd3, 14'h031, 32'hDEAD_BEEF, '1, 2'd2);
        issue(2'd3, 14'h3FFF, 32'hDEAD_BEEF, '1, 2'd0);

        // R4 R5 R6 R7 R8 R9 write or exchange to every number, distinct data
        for (int c = 0; c < 16384; c++)
            issue(c[0] ? 2'd2 : 2'd1, 14'(c), {2'b10, 14'(c), 2'b01, 14'(c)},
                  {c[7:0], 14'(c), c[9:0]}, 2'(c % 3));

        // second exchange pass over the low numbers with a fixed mask (R7)
        for (int c = 0; c < 512; c++)
            issue(2'd2, 14'(c), 32'h0F0F_A5A5 ^ 32'(c), 32'h0F0F_F0F0, 2'd1);

        // reads reveal that undefined and read-only writes had no effect (R4 R5 R9)
        read_sweep();

        // R11 held response and a waiting read of the same register
        req_valid = 1'b1; req_op = 2'd1; req_csr = 14'h031;
        req_wdata = 32'hAAAA_5555; req_mask = '0; req_priv = 2'd0;
        @(posedge clk);
        @(negedge clk);
        resp_ready = 1'b0;
        req_op = 2'd0; req_wdata = '0;
        check("R11", mdl[7], 1'b0, 1'b0, 1'b0);
        mdl[7] = 32'hAAAA_5555;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            checks++;
            if (req_ready !== 1'b0 || resp_valid !== 1'b1) begin
                errors++;
                $display("FAIL R11 stall: ready=%b valid=%b, want 0 1", req_ready, resp_valid);
            end
        end
        resp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R11", 32'hAAAA_5555, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        checks++;
        if (resp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 drain: valid=%b, want 0", resp_valid);
        end

        // R11 back to back: exchange then immediate read sees new value
        issue(2'd2, 14'h181, 32'h1234_5678, 32'hFF00_FF00, 2'd0);
        issue(2'd0, 14'h181, '0, '0, 2'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got timeout, want completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule